// File: doc/BRIEF.md
# Alarm Compare and Timer Event Interrupt Unit

This block watches a running 64-bit time value and compares it against two programmable alarm points. When the time reaches an alarm, the matching event bit is latched and the alarm's output pin is driven to its active level. Alongside the alarms, the block gathers single-cycle event strobes from three periodic pulse sources and two trigger-capture channels into one sticky event register. An enable mask with the same bit layout decides which pending events raise the interrupt line.

Software programs the block over a simple synchronous register bus. An alarm is loaded as two 32-bit halves, low half first. Writing the low half disarms the comparator. Writing the high half then commits the full 64-bit value and arms it, so no match can occur on a half-updated alarm. Pending events are acknowledged by writing ones to their bits. Several events can be acknowledged in a single write.

Top module: `alarm_event_unit`

## Requirements
- R1: After reset the control, event and mask registers read 0, both alarms are disarmed, `irq` is 0 and both alarm pins are 0.
- R2: Register map (word address on `bus_addr`): 0 control, 1 event, 2 mask, 3 alarm 1 low, 4 alarm 1 high, 5 alarm 2 low, 6 alarm 2 high. A low-half write stages the value and disarms that alarm. Only the following high-half write arms it, with the value {high, staged low}.
- R3: An armed alarm matches on a cycle with `time_vld` high when the previous valid time was below the alarm and the new time is at or above it. Alarm 1 sets event bit 16 and alarm 2 sets event bit 17. A match disarms the alarm (one shot). Time values presented with `time_vld` low are ignored.
- R4: A crossing is detected even when the time steps by more than 1, including across the 32-bit half boundary. An alarm armed at a value the time has already passed does not fire.
- R5: `pulse_ev[0]`, `pulse_ev[1]` and `pulse_ev[2]` set event bits 7, 6 and 5. `trig_ev[0]` and `trig_ev[1]` set event bits 24 and 25.
- R6: Writing the event register clears each bit written as 1 and leaves bits written as 0. If a bit is set by a source in the same cycle it is cleared, the set wins.
- R7: `irq` is high exactly while some event bit and the mask bit at the same position are both 1. An event set while masked stays pending and raises `irq` once it is unmasked.
- R8: Control bit 31 selects alarm 1 pin polarity and bit 30 selects alarm 2 pin polarity. A pin reads (fired XOR polarity). The fired state is set by a match and cleared by a low-half write to that alarm.
- R9: Only event and mask bits 25, 24, 17, 16, 7, 6, 5 (0x030300E0) are stored. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current time value |
| time_vld | input | 1 | Qualifies `time_now` for this cycle |
| pulse_ev | input | 3 | Periodic pulse event strobes |
| trig_ev | input | 2 | Trigger-capture event strobes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| alarm_pin | output | 2 | Alarm outputs, bit 0 alarm 1, bit 1 alarm 2 |

## Verification
The comparators are driven with the following time patterns:
- an exact landing on the alarm value, which checks the at-or-above bound;
- a large jump across the 32-bit boundary, which separates crossing detection from equality;
- a jump that stays past an alarm armed late, which shows the comparator uses the previous time and does not simply compare the current time;
- a time value presented with `time_vld` low, which shows unqualified time is not used.

The arming order is tested by writing only a low half and then moving the time across the old alarm and the staged alarm. The event register is tested with single and combined acknowledge patterns, and with a set and a clear landing in the same cycle, which shows the priority between them. The mask is tested with an event pending while masked and then unmasked.

// File: rtl/alarm_event_unit.sv
module alarm_event_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] time_now,
  input  logic        time_vld,
  input  logic [2:0]  pulse_ev,
  input  logic [1:0]  trig_ev,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic [1:0]  alarm_pin
);
  localparam logic [31:0] IMPL = 32'h0303_00E0;

  logic [1:0]  pol_q;
  logic [31:0] evt_q, mask_q;
  logic [63:0] alm_q [2];
  logic [31:0] lo_q  [2];
  logic [1:0]  armed_q, fired_q, hit;
  logic [63:0] prev_q;
  logic        prev_vld_q;
  logic [31:0] set_vec, clr_vec;

  for (genvar k = 0; k < 2; k++) begin : g_cmp
    assign hit[k] = armed_q[k] && time_vld && prev_vld_q &&
                    (prev_q < alm_q[k]) && (time_now >= alm_q[k]);
  end

  always_comb begin
    set_vec = '0;
    set_vec[16] = hit[0];
    set_vec[17] = hit[1];
    set_vec[7]  = pulse_ev[0];
    set_vec[6]  = pulse_ev[1];
    set_vec[5]  = pulse_ev[2];
    set_vec[24] = trig_ev[0];
    set_vec[25] = trig_ev[1];
  end

  assign clr_vec = (bus_wr && bus_addr == 3'd1) ? bus_wdata : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q      <= '0;
      evt_q      <= '0;
      mask_q     <= '0;
      armed_q    <= '0;
      fired_q    <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      for (int k = 0; k < 2; k++) begin
        alm_q[k] <= '0;
        lo_q[k]  <= '0;
      end
    end else begin
      evt_q <= ((evt_q & ~clr_vec) | set_vec) & IMPL;
      if (time_vld) begin
        prev_q     <= time_now;
        prev_vld_q <= 1'b1;
      end
      for (int k = 0; k < 2; k++) begin
        if (hit[k]) begin
          armed_q[k] <= 1'b0;
          fired_q[k] <= 1'b1;
        end
        if (bus_wr && bus_addr == 3'(3 + 2 * k)) begin
          lo_q[k]    <= bus_wdata;
          armed_q[k] <= 1'b0;
          fired_q[k] <= 1'b0;
        end
        if (bus_wr && bus_addr == 3'(4 + 2 * k)) begin
          alm_q[k]   <= {bus_wdata, lo_q[k]};
          armed_q[k] <= 1'b1;
        end
      end
      if (bus_wr && bus_addr == 3'd0) pol_q  <= bus_wdata[31:30];
      if (bus_wr && bus_addr == 3'd2) mask_q <= bus_wdata & IMPL;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {pol_q, 30'h0};
      3'd1:    bus_rdata = evt_q;
      3'd2:    bus_rdata = mask_q;
      3'd3:    bus_rdata = lo_q[0];
      3'd4:    bus_rdata = alm_q[0][63:32];
      3'd5:    bus_rdata = lo_q[1];
      3'd6:    bus_rdata = alm_q[1][63:32];
      default: bus_rdata = 32'h0;
    endcase
  end

  assign irq       = |(evt_q & mask_q);
  assign alarm_pin = {fired_q[1] ^ pol_q[0], fired_q[0] ^ pol_q[1]};
endmodule

module alarm_event_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  pulse_ev,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic        irq,
  input logic [31:0] evt_q,
  input logic [31:0] mask_q,
  input logic [1:0]  armed_q
);
  AST_LO_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> !armed_q[0]); // R2
  AST_HI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4) |=> armed_q[0]); // R2
  AST_ALARM_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[16]) |-> $past(armed_q[0])); // R3
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ev[0] |=> evt_q[7]); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_wr) |=> irq); // R7
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q | mask_q) & ~32'h0303_00E0) == 32'h0); // R9
endmodule

bind alarm_event_unit alarm_event_unit_chk u_chk (.*);

// File: tb/alarm_event_unit_test.sv
module alarm_event_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        time_vld = 1'b0;
  logic [2:0]  pulse_ev = '0;
  logic [1:0]  trig_ev = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [1:0]  alarm_pin;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alarm_event_unit uut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .time_vld(time_vld),
    .pulse_ev(pulse_ev), .trig_ev(trig_ev), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .alarm_pin(alarm_pin)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input logic [63:0] t);
    @(negedge clk);
    time_now = t; time_vld = 1'b1;
    @(negedge clk);
    time_vld = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 event", d, 0);
    rd(3'd2, d); chk("R1 mask", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pins", alarm_pin, 0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R9 mask bits", d, 32'h0303_00E0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_sources();
    logic [31:0] d;
    clear_all();
    @(negedge clk); pulse_ev = 3'b001;
    @(negedge clk); pulse_ev = 3'b000;
    rd(3'd1, d); chk("R5 pulse0 bit7", d, 32'h80);
    @(negedge clk); pulse_ev = 3'b110; trig_ev = 2'b11;
    @(negedge clk); pulse_ev = 3'b000; trig_ev = 2'b00;
    rd(3'd1, d); chk("R5 all sources", d, 32'h0300_00E0);
    chk("R7 masked no irq", irq, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(3'd1, 32'h0100_0060);
    rd(3'd1, d); chk("R6 multi clear", d, 32'h0200_0080);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h80; pulse_ev = 3'b001;
    @(negedge clk);
    bus_wr = 1'b0; pulse_ev = 3'b000;
    rd(3'd1, d); chk("R6 set wins", d, 32'h0200_0080);
    clear_all();
    rd(3'd1, d); chk("R6 clear all", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    @(negedge clk); trig_ev = 2'b01;
    @(negedge clk); trig_ev = 2'b00;
    chk("R7 pending masked", irq, 0);
    wr(3'd2, 32'h0200_0000);
    chk("R7 other bit mask", irq, 0);
    wr(3'd2, 32'h0100_0000);
    chk("R7 unmask raises", irq, 1);
    wr(3'd1, 32'h0100_0000);
    chk("R7 ack drops", irq, 0);
    rd(3'd1, d); chk("R7 event cleared", d, 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_alarm_basic();
    logic [31:0] d;
    clear_all();
    wr(3'd3, 32'd100); wr(3'd4, 32'd0);
    tick(64'd90);
    rd(3'd1, d); chk("R3 below no fire", d, 0);
    tick(64'd99);
    @(negedge clk); time_now = 64'd120; time_vld = 1'b0;
    @(negedge clk);
    rd(3'd1, d); chk("R3 invalid time ignored", d, 0);
    tick(64'd100);
    rd(3'd1, d); chk("R3 exact fires bit16", d, 32'h0001_0000);
    clear_all();
    tick(64'd150); tick(64'd300);
    rd(3'd1, d); chk("R3 one shot", d, 0);
  endtask

  task automatic t_arm_order();
    logic [31:0] d;
    clear_all();
    tick(64'd250);
    wr(3'd3, 32'd300); wr(3'd4, 32'd0);
    wr(3'd3, 32'd260);
    tick(64'd400);
    rd(3'd1, d); chk("R2 low write disarms", d, 0);
    wr(3'd4, 32'd0);
    tick(64'd500);
    rd(3'd1, d); chk("R4 armed past no fire", d, 0);
    tick(64'd100); tick(64'd300);
    rd(3'd1, d); chk("R2 staged value used", d, 32'h0001_0000);
    clear_all();
  endtask

  task automatic t_big_step();
    logic [31:0] d;
    wr(3'd5, 32'h10); wr(3'd6, 32'h1);
    tick(64'h0_FFFF_FFF0);
    rd(3'd1, d); chk("R4 before cross", d, 0);
    tick(64'h1_0000_0100);
    rd(3'd1, d); chk("R4 big step bit17", d, 32'h0002_0000);
    clear_all();
    wr(3'd5, 32'h50); wr(3'd6, 32'h1);
    tick(64'h1_0000_0200);
    rd(3'd1, d); chk("R4 late arm no fire", d, 0);
  endtask

  task automatic t_polarity();
    tick(64'd1000);
    wr(3'd3, 32'd1100); wr(3'd4, 32'd0);
    wr(3'd5, 32'd1100); wr(3'd6, 32'd0);
    chk("R8 pins idle", alarm_pin, 2'b00);
    tick(64'd1200);
    chk("R8 both fired", alarm_pin, 2'b11);
    wr(3'd0, 32'h8000_0000);
    chk("R8 alarm1 inverted", alarm_pin, 2'b10);
    wr(3'd5, 32'd5000);
    chk("R8 low write clears fired", alarm_pin, 2'b00);
    wr(3'd0, 32'hC000_0000);
    chk("R8 alarm2 inverted", alarm_pin, 2'b11 ^ 2'b01);
    wr(3'd0, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unimpl();
    t_sources();
    t_w1c();
    t_mask();
    t_alarm_basic();
    t_arm_order();
    t_big_step();
    t_polarity();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule